// File: doc/BRIEF.md
# Register-Driven JTAG Scan Master

This block drives boundary-scan chains from a simple host register port. Each host write carries a command in its address: a device field that must match this block's identifier, a shift-length field, and an operation code. The write data carries up to sixteen bits to be shifted into the chain. The block generates TCK at a quarter of the system clock and walks the TAP controller of the attached targets through the header, shift and exit states. It collects the bits returned on TDO so the host can read them afterwards.

A data scan longer than sixteen bits is split across several writes. The first write emits only the entry sequence and leaves the TAP in Shift-DR. Middle writes emit neither sequence. The final write emits only the exit sequence, which returns the TAP to Run-Test/Idle. A one-hot selection register decides which of the seven target ports see TCK, TMS and TDI. A separate command drives any TAP back to Run-Test/Idle from an unknown state.

Top module: `jtag_shift_master`

## Requirements
- R1: A command is acted on only when host_addr[15:12] equals the device identifier (default 1) and host_addr[7:0] is one of the defined operation codes. Any other command changes no state, starts no scan and gives no read acknowledge.
- R2: A write with operation 0x20 loads host_wdata[6:0] into the target select, with bit i enabling target i. A read with operation 0x24 returns the select, zero-extended. TCK, TMS and TDI of every unselected target stay at 0, and TDO is taken only from selected targets.
- R3: While a scan runs, TCK is the system clock divided by four: two cycles low, then two cycles high. TCK stays low while the block is idle.
- R4: TMS and TDI change only while TCK is low (at its falling edge) and are stable while TCK is high. TDO is sampled at the rising edge of TCK.
- R5: A data scan shifts host_addr[11:8]+1 bits of host_wdata, least significant bit first. Operations 0x04 and 0x0C prepend the entry sequence TMS 1,0,0 (Idle to Shift-DR). Operations 0x08 and 0x0C raise TMS on the last bit and then emit TMS 1,0 (Exit1 to Update to Idle). Operation 0x00 emits neither sequence.
- R6: Operation 0x1C shifts host_addr[11:8]+1 bits into the instruction register. It uses the entry sequence TMS 1,1,0,0, raises TMS on the last bit, then emits TMS 1,0, ending in Run-Test/Idle.
- R7: A read with operation 0x14 returns the TDO bits captured during the most recent data or instruction scan, right-aligned. The first captured bit is at bit 0, and bits above the scan length are 0.
- R8: Operation 0x18 emits six TCK cycles with TMS 1,1,1,1,1,0, which ends in Run-Test/Idle from any TAP state. Its write data is ignored.
- R9: busy rises the cycle after a scan is accepted and stays high for exactly four cycles per TCK period of the scan. Any write that arrives while busy is high is ignored.
- R10: A 32-bit register is read by a 16-bit header-only scan followed by a 16-bit tailer-only scan. The two TDO reads give its low and high halves.
- R11: A valid read returns its data on host_rdata with host_rvalid high in the following cycle, and host_rvalid is low otherwise.
- R12: After reset, busy, host_rvalid and every target output are 0, and the target select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_valid | input | 1 | Command strobe, one cycle per command |
| host_write | input | 1 | 1 for write, 0 for read |
| host_addr | input | 16 | Command: device [15:12], length-1 [11:8], operation [7:0] |
| host_wdata | input | 16 | Scan data or select value |
| host_rdata | output | 16 | Read data |
| host_rvalid | output | 1 | Read data valid |
| busy | output | 1 | Scan in progress |
| tgt_tck | output | 7 | TCK per target |
| tgt_tms | output | 7 | TMS per target |
| tgt_tdi | output | 7 | TDI per target |
| tgt_tdo | input | 7 | TDO per target |

## Verification
The hardest state to reach is a split scan, where the TAP is left in Shift-DR between two writes. Getting there requires a header-only command, then a headerless middle or tailer-only command. The bench models a full TAP controller with an instruction register, a bypass bit and a 32-bit identification register. It then chains 0x04, 0x00 and 0x08 scans and checks that each bit carried over from the previous write appears at bit 0 of the next TDO read. It also issues writes in the middle of a running scan and then counts TCK edges and reads the select back, to show those writes had no effect.

// File: rtl/jtag_shm_pkg.sv
// Shared definitions for the JTAG scan master: operation codes, sequencer
// segments and the scan-kind descriptor passed from decode to sequencer.
package jtag_shm_pkg;

    localparam logic [7:0] OP_DATA      = 8'h00;
    localparam logic [7:0] OP_DATA_HDR  = 8'h04;
    localparam logic [7:0] OP_DATA_TAIL = 8'h08;
    localparam logic [7:0] OP_DATA_BOTH = 8'h0C;
    localparam logic [7:0] OP_TDO_RD    = 8'h14;
    localparam logic [7:0] OP_TAP_IDLE  = 8'h18;
    localparam logic [7:0] OP_INSTR     = 8'h1C;
    localparam logic [7:0] OP_SEL_WR    = 8'h20;
    localparam logic [7:0] OP_SEL_RD    = 8'h24;

    typedef enum logic [1:0] {
        SEG_IDLE  = 2'd0,
        SEG_HDR   = 2'd1,
        SEG_SHIFT = 2'd2,
        SEG_TAIL  = 2'd3
    } seg_e;

    typedef struct packed {
        logic to_idle;  // TAP return sequence only
        logic instr;    // instruction-register path
        logic hdr;      // emit entry sequence
        logic tail;     // emit exit sequence
    } scan_kind_t;

endpackage

// File: rtl/jsm_tck_div.sv
// TCK divider. Assumes run is high for whole TCK periods only; phase is held
// at zero while idle so every scan begins with TCK low.
module jsm_tck_div (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tck,
    output logic sample,
    output logic step_end
);
    logic [1:0] phase_q;

    // Purpose: advance the four-cycle TCK phase while a scan runs.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= 2'd0;
        else if (!run) phase_q <= 2'd0;
        else           phase_q <= phase_q + 2'd1;
    end

    assign tck      = run & phase_q[1];
    assign sample   = run & (phase_q == 2'd1);   // edge where TCK rises
    assign step_end = run & (phase_q == 2'd3);   // edge where TCK falls
endmodule

// File: rtl/jsm_seq.sv
// TAP sequencer. Produces one TMS/TDI pair per TCK period, walking the header,
// shift and tailer segments. Assumes start is only pulsed while idle.
module jsm_seq
    import jtag_shm_pkg::*;
#(
    parameter int SHIFT_W = 16,
    localparam int LEN_W  = $clog2(SHIFT_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  scan_kind_t         kind_i,
    input  logic [LEN_W-1:0]   len_m1_i,
    input  logic [SHIFT_W-1:0] data_i,
    input  logic               step_end,
    output logic               busy_o,
    output logic               tms_o,
    output logic               tdi_o,
    output logic               shifting_o
);
    seg_e               seg_q;
    scan_kind_t         kind_q;
    logic [LEN_W-1:0]   idx_q;
    logic [LEN_W-1:0]   len_m1_q;
    logic [SHIFT_W-1:0] sh_q;
    logic [LEN_W-1:0]   hdr_last;

    // Purpose: index of the final header step for the active scan kind.
    always_comb begin
        if (kind_q.to_idle)    hdr_last = LEN_W'(5);
        else if (kind_q.instr) hdr_last = LEN_W'(3);
        else                   hdr_last = LEN_W'(2);
    end

    // Purpose: segment/step state, loaded on start and advanced each TCK period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q    <= SEG_IDLE;
            kind_q   <= '0;
            idx_q    <= '0;
            len_m1_q <= '0;
            sh_q     <= '0;
        end else if (start) begin
            kind_q   <= kind_i;
            len_m1_q <= len_m1_i;
            sh_q     <= data_i;
            idx_q    <= '0;
            seg_q    <= kind_i.hdr ? SEG_HDR : SEG_SHIFT;
        end else if (step_end) begin
            unique case (seg_q)
                SEG_HDR: begin
                    if (idx_q == hdr_last) begin
                        idx_q <= '0;
                        seg_q <= kind_q.to_idle ? SEG_IDLE : SEG_SHIFT;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                SEG_SHIFT: begin
                    sh_q <= sh_q >> 1;
                    if (idx_q == len_m1_q) begin
                        idx_q <= '0;
                        seg_q <= kind_q.tail ? SEG_TAIL : SEG_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                SEG_TAIL: begin
                    if (idx_q == LEN_W'(1)) begin
                        idx_q <= '0;
                        seg_q <= SEG_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: seg_q <= SEG_IDLE;
            endcase
        end
    end

    // Purpose: TMS level for the current step.
    always_comb begin
        unique case (seg_q)
            SEG_HDR: begin
                if (kind_q.to_idle)    tms_o = (idx_q < LEN_W'(5));
                else if (kind_q.instr) tms_o = (idx_q < LEN_W'(2));
                else                   tms_o = (idx_q == '0);
            end
            SEG_SHIFT: tms_o = kind_q.tail && (idx_q == len_m1_q);
            SEG_TAIL:  tms_o = (idx_q == '0);
            default:   tms_o = 1'b0;
        endcase
    end

    assign tdi_o      = (seg_q == SEG_SHIFT) & sh_q[0];
    assign shifting_o = (seg_q == SEG_SHIFT);
    assign busy_o     = (seg_q != SEG_IDLE);
endmodule

// File: rtl/jsm_tdo_cap.sv
// TDO capture. Shifts in one bit per sampled shift step; presents the most
// recent scan right-aligned. Assumes a new scan's length is loaded on start.
module jsm_tdo_cap #(
    parameter int SHIFT_W = 16,
    localparam int LEN_W  = $clog2(SHIFT_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_len,
    input  logic [LEN_W-1:0]   len_m1_i,
    input  logic               sample,
    input  logic               tdo_i,
    output logic [SHIFT_W-1:0] rd_o
);
    logic [SHIFT_W-1:0] cap_q;
    logic [LEN_W:0]     len_q;
    logic [LEN_W:0]     drop;

    // Purpose: record the scan length at the start of each scan.
    always_ff @(posedge clk) begin
        if (!rst_n)        len_q <= (LEN_W+1)'(SHIFT_W);
        else if (load_len) len_q <= {1'b0, len_m1_i} + 1'b1;
    end

    // Purpose: shift sampled TDO bits in from the top.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= '0;
        else if (sample) cap_q <= {tdo_i, cap_q[SHIFT_W-1:1]};
    end

    assign drop = (LEN_W+1)'(SHIFT_W) - len_q;
    assign rd_o = cap_q >> drop;
endmodule

// File: rtl/jsm_route.sv
// Target fan-out. Gates the JTAG outputs by the one-hot select and merges
// TDO from the selected targets.
module jsm_route #(
    parameter int N_TGT = 7
) (
    input  logic [N_TGT-1:0] sel,
    input  logic             tck,
    input  logic             tms,
    input  logic             tdi,
    input  logic [N_TGT-1:0] tdo_in,
    output logic [N_TGT-1:0] tck_out,
    output logic [N_TGT-1:0] tms_out,
    output logic [N_TGT-1:0] tdi_out,
    output logic             tdo_out
);
    for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
        assign tck_out[g] = sel[g] & tck;
        assign tms_out[g] = sel[g] & tms;
        assign tdi_out[g] = sel[g] & tdi;
    end

    assign tdo_out = |(tdo_in & sel);
endmodule

// File: rtl/jtag_shift_master.sv
// Top of the JTAG scan master: decodes host commands, holds the target
// select, and ties divider, sequencer, capture and routing together.
// Assumes one command per host_valid pulse and SHIFT_W equal to HOST_W.
module jtag_shift_master
    import jtag_shm_pkg::*;
#(
    parameter logic [3:0] DEV_ID = 4'd1,
    parameter int N_TGT   = 7,
    parameter int HOST_W  = 16,
    localparam int LEN_W  = $clog2(HOST_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [15:0]       host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              busy,
    output logic [N_TGT-1:0]  tgt_tck,
    output logic [N_TGT-1:0]  tgt_tms,
    output logic [N_TGT-1:0]  tgt_tdi,
    input  logic [N_TGT-1:0]  tgt_tdo
);
    logic [N_TGT-1:0]  sel_q;
    logic              dev_hit;
    logic [7:0]        op;
    logic [LEN_W-1:0]  len_m1;
    logic              scan_op;
    scan_kind_t        kind;
    logic              start;
    logic              sel_wr;
    logic              rd_hit;
    logic              tck;
    logic              sample;
    logic              step_end;
    logic              tms;
    logic              tdi;
    logic              shifting;
    logic              tdo;
    logic [HOST_W-1:0] cap_rd;

    assign dev_hit = (host_addr[15:12] == DEV_ID);
    assign op      = host_addr[7:0];
    assign len_m1  = host_addr[8 +: LEN_W];

    // Purpose: classify the operation code into a scan kind.
    always_comb begin
        scan_op = 1'b1;
        kind    = '0;
        unique case (op)
            OP_DATA:      kind = '0;
            OP_DATA_HDR:  kind.hdr = 1'b1;
            OP_DATA_TAIL: kind.tail = 1'b1;
            OP_DATA_BOTH: begin kind.hdr = 1'b1; kind.tail = 1'b1; end
            OP_INSTR:     begin kind.instr = 1'b1; kind.hdr = 1'b1; kind.tail = 1'b1; end
            OP_TAP_IDLE:  begin kind.to_idle = 1'b1; kind.hdr = 1'b1; end
            default:      scan_op = 1'b0;
        endcase
    end

    assign start  = host_valid & host_write & dev_hit & !busy & scan_op;
    assign sel_wr = host_valid & host_write & dev_hit & !busy & (op == OP_SEL_WR);
    assign rd_hit = host_valid & !host_write & dev_hit &
                    ((op == OP_TDO_RD) || (op == OP_SEL_RD));

    // Purpose: one-hot target select register.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_wr) sel_q <= host_wdata[N_TGT-1:0];
    end

    // Purpose: registered read return with a one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= rd_hit;
            if (rd_hit)
                host_rdata <= (op == OP_TDO_RD) ? cap_rd
                                                : {{(HOST_W-N_TGT){1'b0}}, sel_q};
        end
    end

    jsm_tck_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .tck      (tck),
        .sample   (sample),
        .step_end (step_end)
    );

    jsm_seq #(.SHIFT_W(HOST_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .kind_i     (kind),
        .len_m1_i   (len_m1),
        .data_i     (host_wdata),
        .step_end   (step_end),
        .busy_o     (busy),
        .tms_o      (tms),
        .tdi_o      (tdi),
        .shifting_o (shifting)
    );

    jsm_tdo_cap #(.SHIFT_W(HOST_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_len (start & !kind.to_idle),
        .len_m1_i (len_m1),
        .sample   (sample & shifting),
        .tdo_i    (tdo),
        .rd_o     (cap_rd)
    );

    jsm_route #(.N_TGT(N_TGT)) u_route (
        .sel     (sel_q),
        .tck     (tck),
        .tms     (tms),
        .tdi     (tdi),
        .tdo_in  (tgt_tdo),
        .tck_out (tgt_tck),
        .tms_out (tgt_tms),
        .tdi_out (tgt_tdi),
        .tdo_out (tdo)
    );
endmodule

// File: rtl/jtag_shift_master_chk.sv
// Property checker for the JTAG scan master, attached by bind.
module jtag_shift_master_chk #(
    parameter logic [3:0] DEV_ID = 4'd1,
    parameter int N_TGT = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_valid,
    input logic             host_write,
    input logic [15:0]      host_addr,
    input logic             host_rvalid,
    input logic             busy,
    input logic [N_TGT-1:0] tgt_tck,
    input logic [N_TGT-1:0] tgt_tms,
    input logic [N_TGT-1:0] tgt_tdi,
    input logic [N_TGT-1:0] sel_q
);
    logic any_tck;
    assign any_tck = |tgt_tck;

    p_tck_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_tck) |=> any_tck ##1 !any_tck);

    p_tck_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tgt_tck == '0));

    p_pins_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any_tck |-> ($stable(tgt_tms) && $stable(tgt_tdi)));

    p_unsel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (((tgt_tck | tgt_tms | tgt_tdi) & ~sel_q) == '0));

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_valid && host_write) |=> $stable(sel_q));

    p_wrong_dev_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_addr[15:12] != DEV_ID) |=>
            ($stable(sel_q) && !$rose(busy) && !host_rvalid));

    p_read_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_write && host_addr[15:12] == DEV_ID &&
         (host_addr[7:0] == 8'h14 || host_addr[7:0] == 8'h24)) |=> host_rvalid);

    p_no_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |=> !host_rvalid);
endmodule

bind jtag_shift_master jtag_shift_master_chk #(.DEV_ID(DEV_ID), .N_TGT(N_TGT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_valid  (host_valid),
    .host_write  (host_write),
    .host_addr   (host_addr),
    .host_rvalid (host_rvalid),
    .busy        (busy),
    .tgt_tck     (tgt_tck),
    .tgt_tms     (tgt_tms),
    .tgt_tdi     (tgt_tdi),
    .sel_q       (sel_q)
);

// File: tb/jtag_shift_master_test.sv
// Bench: drives host commands and models a TAP controller on target 2 with a
// 10-bit instruction register, a bypass bit and a 32-bit ID register.
module jtag_shift_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [15:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        busy;
    logic [6:0]  tgt_tck, tgt_tms, tgt_tdi, tgt_tdo;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] IDCODE = 32'hA5C3_DBDB;
    localparam logic [9:0]  IR_ID  = 10'h3C8;
    localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHD = 4, E1D = 5, PDR = 6,
                   E2D = 7, UDR = 8, SIR = 9, CIR = 10, SHI = 11, E1I = 12,
                   PIR = 13, E2I = 14, UIR = 15;

    always #4 clk = ~clk;

    jtag_shift_master uut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .busy(busy), .tgt_tck(tgt_tck),
        .tgt_tms(tgt_tms), .tgt_tdi(tgt_tdi), .tgt_tdo(tgt_tdo)
    );

    // TAP model on target 2
    int          tap_st = TLR;
    logic [9:0]  ir_sh = '0, ir_q = '0;
    logic [31:0] id_sh = '0;
    logic        byp = 1'b0;
    logic        tap_tdo;

    always_comb begin
        if (tap_st == SHD)      tap_tdo = (ir_q == IR_ID) ? id_sh[0] : byp;
        else if (tap_st == SHI) tap_tdo = ir_sh[0];
        else                    tap_tdo = 1'b0;
    end
    assign tgt_tdo = {4'b0, tap_tdo, 2'b0};

    always @(posedge tgt_tck[2]) begin
        case (tap_st)
            CDR: if (ir_q == IR_ID) id_sh <= IDCODE; else byp <= 1'b0;
            SHD: if (ir_q == IR_ID) id_sh <= {tgt_tdi[2], id_sh[31:1]}; else byp <= tgt_tdi[2];
            CIR: ir_sh <= 10'h001;
            SHI: ir_sh <= {tgt_tdi[2], ir_sh[9:1]};
            UIR: ir_q <= ir_sh;
            default: ;
        endcase
        case (tap_st)
            TLR: tap_st <= tgt_tms[2] ? TLR : RTI;
            RTI: tap_st <= tgt_tms[2] ? SDR : RTI;
            SDR: tap_st <= tgt_tms[2] ? SIR : CDR;
            CDR: tap_st <= tgt_tms[2] ? E1D : SHD;
            SHD: tap_st <= tgt_tms[2] ? E1D : SHD;
            E1D: tap_st <= tgt_tms[2] ? UDR : PDR;
            PDR: tap_st <= tgt_tms[2] ? E2D : PDR;
            E2D: tap_st <= tgt_tms[2] ? UDR : SHD;
            UDR: tap_st <= tgt_tms[2] ? SDR : RTI;
            SIR: tap_st <= tgt_tms[2] ? TLR : CIR;
            CIR: tap_st <= tgt_tms[2] ? E1I : SHI;
            SHI: tap_st <= tgt_tms[2] ? E1I : SHI;
            E1I: tap_st <= tgt_tms[2] ? UIR : PIR;
            PIR: tap_st <= tgt_tms[2] ? E2I : PIR;
            E2I: tap_st <= tgt_tms[2] ? UIR : SHI;
            default: tap_st <= tgt_tms[2] ? SDR : RTI;
        endcase
    end

    // TCK rising-edge counters per target
    int       tck_cnt [7];
    int       base    [7];
    logic [6:0] tck_prev = '0;
    initial for (int i = 0; i < 7; i++) tck_cnt[i] = 0;
    always @(posedge clk) begin
        for (int i = 0; i < 7; i++)
            if (tgt_tck[i] && !tck_prev[i]) tck_cnt[i] <= tck_cnt[i] + 1;
        tck_prev <= tgt_tck;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic host_rd(input logic [15:0] a, output logic [15:0] v, output logic ok);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_addr = a;
        @(negedge clk);
        v = host_rdata; ok = host_rvalid;
        host_valid = 1'b0;
    endtask

    // Issue a scan, return busy cycles and TCK pulses per target.
    int bcyc;
    task automatic scan(input logic [15:0] a, input logic [15:0] d);
        for (int i = 0; i < 7; i++) base[i] = tck_cnt[i];
        host_wr(a, d);
        bcyc = 0;
        while (busy) begin bcyc++; @(negedge clk); end
        repeat (2) @(negedge clk);
    endtask

    function automatic int pulses(input int t);
        return tck_cnt[t] - base[t];
    endfunction

    logic [15:0] rv;
    logic        rok;

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "busy in reset", {31'b0, busy}, 32'd0);
        check("R12", "tck in reset", {25'b0, tgt_tck}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "rvalid after reset", {31'b0, host_rvalid}, 32'd0);
        host_rd(16'h1024, rv, rok);
        check("R12", "select after reset", {16'b0, rv}, 32'd0);
        check("R11", "read ack", {31'b0, rok}, 32'd1);

        // R2 select target 2
        host_wr(16'h1020, 16'hFF84);
        host_rd(16'h1024, rv, rok);
        check("R2", "select readback", {16'b0, rv}, 32'h04);

        // R8 return to idle, data ignored
        scan(16'h1018, 16'hFFFF);
        check("R8", "TAP state", tap_st, RTI);
        check("R8", "tck pulses", pulses(2), 6);
        check("R9", "busy cycles reset op", bcyc, 24);
        check("R2", "unselected target pulses", pulses(0) + pulses(5), 0);

        // R6 instruction scan; R7 captured IR bits
        scan(16'h191C, 16'h03C8);
        check("R6", "IR value", {22'b0, ir_q}, {22'b0, IR_ID});
        check("R6", "TAP state", tap_st, RTI);
        check("R6", "tck pulses", pulses(2), 4 + 10 + 2);
        host_rd(16'h1014, rv, rok);
        check("R7", "IR capture readback", {16'b0, rv}, 32'h001);

        // R10 32-bit read split in two
        scan(16'h1F04, 16'h0000);
        check("R10", "state after header-only", tap_st, SHD);
        host_rd(16'h1014, rv, rok);
        check("R10", "low half", {16'b0, rv}, {16'b0, IDCODE[15:0]});
        scan(16'h1F08, 16'h0000);
        check("R10", "state after tailer-only", tap_st, RTI);
        host_rd(16'h1014, rv, rok);
        check("R10", "high half", {16'b0, rv}, {16'b0, IDCODE[31:16]});

        // Select bypass path
        scan(16'h191C, 16'h0155);
        check("R6", "IR bypass value", {22'b0, ir_q}, 32'h155);

        // R5 sweep of lengths and patterns through bypass, full header+tailer
        for (int len = 1; len <= 16; len++) begin
            for (int p = 0; p < 3; p++) begin
                logic [15:0] d;
                logic [15:0] mask;
                d = (p == 0) ? 16'hA5C3 : (p == 1) ? 16'h5A3C : 16'(len * 16'h1357 + 16'h0F0F);
                mask = 16'((32'd1 << len) - 1);
                scan({4'h1, 4'(len - 1), 8'h0C}, d);
                host_rd(16'h1014, rv, rok);
                check("R7", "bypass readback", {16'b0, rv}, {16'b0, (d << 1) & mask});
                check("R5", "tck pulses", pulses(2), 3 + len + 2);
                check("R9", "busy cycles", bcyc, 4 * (3 + len + 2));
                check("R5", "TAP state", tap_st, RTI);
            end
        end

        // R5 split chain: header-only, plain, tailer-only
        scan(16'h1304, 16'h000A);          // 4 bits 1010
        check("R5", "hdr-only state", tap_st, SHD);
        check("R5", "hdr-only pulses", pulses(2), 7);
        host_rd(16'h1014, rv, rok);
        check("R5", "hdr-only read", {16'b0, rv}, 32'h4);
        scan(16'h1200, 16'h0005);          // 3 bits 101, first out = previous bit 3 (1)
        check("R5", "plain state", tap_st, SHD);
        check("R5", "plain pulses", pulses(2), 3);
        host_rd(16'h1014, rv, rok);
        check("R5", "plain read", {16'b0, rv}, 32'h3);
        scan(16'h1108, 16'h0002);          // 2 bits 10, first out = previous bit 2 (1)
        check("R5", "tail-only state", tap_st, RTI);
        check("R5", "tail-only pulses", pulses(2), 4);
        host_rd(16'h1014, rv, rok);
        check("R5", "tail-only read", {16'b0, rv}, 32'h1);

        // R8 from mid-scan
        scan(16'h1004, 16'h0001);
        scan(16'h1018, 16'h0000);
        check("R8", "idle from shift-DR", tap_st, RTI);

        // R9 writes during busy are ignored
        for (int i = 0; i < 7; i++) base[i] = tck_cnt[i];
        host_wr(16'h1F0C, 16'h1234);
        host_wr(16'h1020, 16'h007F);
        host_wr(16'h1F0C, 16'hFFFF);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R9", "pulses with writes while busy", pulses(2), 21);
        check("R9", "other target quiet", pulses(6), 0);
        host_rd(16'h1024, rv, rok);
        check("R9", "select unchanged", {16'b0, rv}, 32'h04);

        // R1 wrong device / unknown op
        host_wr(16'h2020, 16'h007F);
        host_rd(16'h1024, rv, rok);
        check("R1", "select after wrong device", {16'b0, rv}, 32'h04);
        host_wr(16'h2F0C, 16'h0000);
        check("R1", "busy after wrong device", {31'b0, busy}, 32'd0);
        host_wr(16'h1F30, 16'h0000);
        check("R1", "busy after unknown op", {31'b0, busy}, 32'd0);
        host_rd(16'h2024, rv, rok);
        check("R1", "no ack wrong device read", {31'b0, rok}, 32'd0);
        host_rd(16'h1030, rv, rok);
        check("R11", "no ack unknown read", {31'b0, rok}, 32'd0);

        // R2/R3 two targets selected
        host_wr(16'h1020, 16'h0005);
        scan(16'h1000, 16'h0000);
        check("R2", "target0 pulses", pulses(0), 1);
        check("R2", "target2 pulses", pulses(2), 1);
        check("R2", "target1 pulses", pulses(1), 0);
        check("R3", "busy cycles one bit", bcyc, 4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule